// File: doc/BRIEF.md
# Shared DRAM Timing Controller with Video Burst Priority

This controller drives the timing of one DRAM channel that serves two masters: a CPU port and a video fetch port. The CPU moves a single 16-bit word per access, and a 32-bit CPU request is carried out as two word accesses at consecutive word addresses. The video port fetches fixed page-mode bursts of 17 longs. A burst opens a row once, then runs one column cycle per long. The controller also forces a periodic refresh. It adds two precharge cycles whenever a CPU word does not continue the open row sequentially.

Arbitration happens only at an arbitration point: the controller is idle, or it is in the last cycle of a CPU word, of a burst or of a refresh. At that point a pending refresh wins first, then the video port, then the CPU. Work already started is never cut short. The CPU holds its request, width and address stable until its final acknowledge. The video port holds its request until the burst-done pulse.

Cycle counts below are counted in clock edges after the first edge that samples the request while the controller is at an arbitration point. Word addresses are used throughout. A row is the word address with its low `COL_W` bits removed.

Top module: `dram_share_ctrl`

## Requirements
- R1: A CPU word whose address is the previous CPU word address plus one, in the same row with the row still open, raises `cpu_ack` for exactly one cycle, 4 cycles after the request is sampled.
- R2: Any other CPU word pays 2 precharge cycles first, with `ras_n` and `cas_n` both high, and acknowledges after 6 cycles. This covers the first word after reset, a repeated address, a jump, or a change of row.
- R3: A CPU long (`cpu_long`=1) runs as two words, at `cpu_addr` and `cpu_addr`+1, each with its own acknowledge and with `mem_addr` holding that word's address. The second word costs 4 more cycles, or 6 when it crosses into the next row.
- R4: A video burst spends 2 row cycles and then raises `vid_valid` for 17 consecutive cycles, the first of them 3 cycles after the request. On beat k, `mem_addr` equals 2·`vid_addr`+2k. `vid_done` pulses in the cycle after the last beat.
- R5: When the video and CPU requests are both present at an arbitration point, the burst goes first. A CPU word requested together with a burst from idle acknowledges 25 cycles after the request.
- R6: A CPU request raised during a burst leaves the 17 beats contiguous. The CPU word starts only after the burst ends.
- R7: On an idle controller, a refresh starts every `REF_INTERVAL` cycles (default 250) and lasts `REF_LEN` cycles (default 4). A refresh is marked by `cas_n` low while `mux_col` is 0.
- R8: A due refresh is served before a waiting CPU word and delays it by the refresh length. A refresh that falls due during a burst waits until the burst ends.
- R9: After a refresh or a burst, the open row is forgotten, so the next CPU word pays precharge even if it is sequential.
- R10: `cpu_wait` is high in every cycle in which `cpu_req` is high and `cpu_ack` is low.
- R11: Strobe encoding. At idle, `ras_n`, `cas_n` and `we_n` are high. In a CPU row cycle, `ras_n` is low and `mux_col` is 0. In a CPU column cycle, `ras_n` and `cas_n` are low and `mux_col` is 1. `we_n` is low only in the column cycles of a CPU write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until the last acknowledge |
| cpu_long | input | 1 | 1: 32-bit request (two words), 0: one word |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_ack | output | 1 | One-cycle pulse per completed word |
| cpu_wait | output | 1 | CPU must keep waiting |
| vid_req | input | 1 | Video burst request, held until `vid_done` |
| vid_addr | input | ADDR_W-1 | Burst start address in longs |
| vid_valid | output | 1 | One pulse per delivered long |
| vid_done | output | 1 | Pulse after the final long |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mux_col | output | 1 | Address mux: 1 drives the column half, 0 the row half |
| mem_addr | output | ADDR_W | Word address of the current access |

## Verification
Isolated CPU words and longs are tried in several patterns: sequential, repeated, jumping and row-crossing addresses. These separate the 4-cycle path from the 6-cycle precharge path, and row continuation from mere address adjacency. Bursts run alone, with a CPU request raised at varied offsets, and together with a CPU request from idle. These show the fixed burst shape, the priority of video and the loss of the open row afterwards. A constrained random mix of these cases is scored against a bench model of the open row. A second instance with the default refresh interval is used to time the refresh period. That instance also collides a CPU word with a due refresh.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CROW,
    ST_CCOL,
    ST_VROW,
    ST_VCOL,
    ST_REF
  } phase_e;

  // Cycles for one CPU word: one row cycle plus three column cycles,
  // preceded by the precharge time when the access is not sequential.
  function automatic int unsigned word_cycles(bit seq, int unsigned pre_len);
    return (seq ? 0 : pre_len) + 4;
  endfunction

  // Cycles the memory is busy for one video burst.
  function automatic int unsigned burst_cycles(int unsigned row_len, int unsigned beats);
    return row_len + beats;
  endfunction

endpackage

// File: rtl/dsc_ref_timer.sv
module dsc_ref_timer #(
  parameter int REF_INTERVAL = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_start,
  output logic ref_pend
);
  localparam int CW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

  logic [CW-1:0] tick_cnt;
  logic          ref_tick;

  assign ref_tick = (tick_cnt == CW'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      ref_pend <= 1'b0;
    end else begin
      tick_cnt <= ref_tick ? '0 : tick_cnt + 1'b1;
      ref_pend <= (ref_pend & ~ref_start) | ref_tick;
    end
  end

  // R7: a refresh that has been started is no longer pending next cycle
  a_r7_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_start && !ref_tick) |=> !ref_pend);

endmodule

// File: rtl/dsc_row_track.sv
module dsc_row_track #(
  parameter int ADDR_W = 22,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [ADDR_W-1:0] done_addr,
  input  logic              invalidate,
  input  logic [ADDR_W-1:0] cand_addr,
  output logic              cand_seq
);
  localparam int ROW_W = ADDR_W - COL_W;

  logic [ADDR_W-1:0] last_addr;
  logic              open_ok;
  logic [ADDR_W-1:0] ref_addr;
  logic              ref_ok;
  logic [ADDR_W-1:0] next_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_addr <= '0;
      open_ok   <= 1'b0;
    end else if (invalidate) begin
      open_ok   <= 1'b0;
    end else if (word_done) begin
      open_ok   <= 1'b1;
      last_addr <= done_addr;
    end
  end

  // bypass the word finishing this cycle so back-to-back words see it
  assign ref_addr  = word_done ? done_addr : last_addr;
  assign ref_ok    = word_done | open_ok;
  assign next_addr = ref_addr + 1'b1;
  assign cand_seq  = ref_ok && (cand_addr == next_addr) &&
                     (cand_addr[ADDR_W-1 -: ROW_W] == ref_addr[ADDR_W-1 -: ROW_W]);

  // R9: refresh or burst start forgets the open row
  a_r9_row_forgotten: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |=> !cand_seq);

endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int BURST_LEN = 17,
  parameter int VROW_LEN  = 2,
  parameter int PRE_LEN   = 2,
  parameter int REF_LEN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_long,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              vid_req,
  input  logic [ADDR_W-2:0] vid_addr,
  input  logic              ref_pend,
  input  logic              cand_seq,
  output logic [ADDR_W-1:0] cand_addr,
  output logic              word_done,
  output logic [ADDR_W-1:0] done_addr,
  output logic              row_drop,
  output logic              ref_start,
  output logic              cpu_ack,
  output logic              vid_valid,
  output logic              vid_done,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              mux_col,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int CCOL_LEN    = int'(word_cycles(1'b1, 0)) - 1;
  localparam int BURST_TOTAL = int'(burst_cycles(VROW_LEN, BURST_LEN));
  localparam int M1      = (BURST_LEN > REF_LEN) ? BURST_LEN : REF_LEN;
  localparam int M2      = (PRE_LEN > VROW_LEN) ? PRE_LEN : VROW_LEN;
  localparam int M3      = (M1 > M2) ? M1 : M2;
  localparam int CNT_MAX = (M3 > CCOL_LEN) ? M3 : CCOL_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int VC_W    = $clog2(BURST_TOTAL + 2);

  phase_e            st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              half_q, half_n;
  logic [ADDR_W-2:0] vbase;
  logic              vdone_q;

  logic fin_ccol, fin_vcol, fin_ref, decide;
  logic cpu_more, cpu_elig, vid_elig, vid_start;
  logic [ADDR_W-1:0] cur_addr;

  // events of the current cycle, named for the assertions
  assign fin_ccol = (st == ST_CCOL) && (cnt == CNT_W'(CCOL_LEN - 1));
  assign fin_vcol = (st == ST_VCOL) && (cnt == CNT_W'(BURST_LEN - 1));
  assign fin_ref  = (st == ST_REF)  && (cnt == CNT_W'(REF_LEN - 1));
  assign decide   = (st == ST_IDLE) || fin_ccol || fin_vcol || fin_ref;

  assign cpu_more = fin_ccol && cpu_long && !half_q;
  assign cpu_elig = cpu_req && (!fin_ccol || cpu_more);
  assign vid_elig = vid_req && !fin_vcol;

  assign ref_start = decide && ref_pend;
  assign vid_start = decide && !ref_pend && vid_elig;
  assign row_drop  = ref_start || vid_start;

  assign half_n    = fin_ccol ? cpu_more : half_q;
  assign cur_addr  = cpu_addr + {{(ADDR_W-1){1'b0}}, half_q};
  assign cand_addr = cpu_addr + {{(ADDR_W-1){1'b0}}, half_n};
  assign word_done = fin_ccol;
  assign done_addr = cur_addr;

  always_comb begin
    st_n  = st;
    cnt_n = cnt + 1'b1;
    if (decide) begin
      cnt_n = '0;
      if (ref_pend)      st_n = ST_REF;
      else if (vid_elig) st_n = ST_VROW;
      else if (cpu_elig) st_n = cand_seq ? ST_CROW : ST_PRE;
      else               st_n = ST_IDLE;
    end else begin
      unique case (st)
        ST_PRE: if (cnt == CNT_W'(PRE_LEN - 1)) begin
          st_n  = ST_CROW;
          cnt_n = '0;
        end
        ST_CROW: begin
          st_n  = ST_CCOL;
          cnt_n = '0;
        end
        ST_VROW: if (cnt == CNT_W'(VROW_LEN - 1)) begin
          st_n  = ST_VCOL;
          cnt_n = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      half_q  <= 1'b0;
      vbase   <= '0;
      vdone_q <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      half_q  <= half_n;
      vdone_q <= fin_vcol;
      if (vid_start) vbase <= vid_addr;
    end
  end

  always_comb begin
    ras_n    = 1'b1;
    cas_n    = 1'b1;
    mux_col  = 1'b0;
    mem_addr = '0;
    unique case (st)
      ST_PRE:  mem_addr = cur_addr;
      ST_CROW: begin
        ras_n    = 1'b0;
        mem_addr = cur_addr;
      end
      ST_CCOL: begin
        ras_n    = 1'b0;
        cas_n    = 1'b0;
        mux_col  = 1'b1;
        mem_addr = cur_addr;
      end
      ST_VROW: begin
        ras_n    = 1'b0;
        mem_addr = {vbase, 1'b0};
      end
      ST_VCOL: begin
        ras_n    = 1'b0;
        cas_n    = 1'b0;
        mux_col  = 1'b1;
        mem_addr = {vbase, 1'b0} + ADDR_W'({cnt, 1'b0});
      end
      ST_REF: begin
        cas_n = 1'b0;
        ras_n = (cnt == '0);
      end
      default: ;
    endcase
  end

  assign cpu_ack   = fin_ccol;
  assign vid_valid = (st == ST_VCOL);
  assign vid_done  = vdone_q;
  assign we_n      = !(cpu_we && st == ST_CCOL);

  // cycles spent on the current burst, for the bound check
  logic [VC_W-1:0] vcyc;
  always_ff @(posedge clk) begin
    if (!rst_n)                             vcyc <= '0;
    else if (st_n == ST_VROW && vid_start)  vcyc <= VC_W'(1);
    else if (st == ST_VROW || st == ST_VCOL) vcyc <= vcyc + 1'b1;
    else                                    vcyc <= '0;
  end

  a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  a_r11_col_after_row: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CCOL && cnt == '0) |-> $past(st == ST_CROW));

  a_r4_beats_after_row: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vid_valid) |-> $past(st == ST_VROW));

  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    vid_done |-> (!vid_valid && $past(vid_valid)));

  a_r4_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_VROW || st == ST_VCOL) |-> (vcyc <= VC_W'(BURST_TOTAL)));

  a_r5_video_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !ref_pend && vid_req && cpu_req && !fin_vcol) |=> (st == ST_VROW));

  a_r8_ref_waits_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_VCOL && ref_pend && !fin_vcol) |=> (st == ST_VCOL));

endmodule

// File: rtl/dram_share_ctrl.sv
module dram_share_ctrl #(
  parameter int ADDR_W       = 22,
  parameter int COL_W        = 9,
  parameter int BURST_LEN    = 17,
  parameter int VROW_LEN     = 2,
  parameter int PRE_LEN      = 2,
  parameter int REF_LEN      = 4,
  parameter int REF_INTERVAL = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_long,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ack,
  output logic              cpu_wait,
  input  logic              vid_req,
  input  logic [ADDR_W-2:0] vid_addr,
  output logic              vid_valid,
  output logic              vid_done,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              mux_col,
  output logic [ADDR_W-1:0] mem_addr
);
  logic              ref_pend, ref_start, cand_seq, word_done, row_drop;
  logic [ADDR_W-1:0] cand_addr, done_addr;

  dsc_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_start(ref_start), .ref_pend(ref_pend)
  );

  dsc_row_track #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .done_addr(done_addr),
    .invalidate(row_drop), .cand_addr(cand_addr), .cand_seq(cand_seq)
  );

  dsc_sequencer #(
    .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .VROW_LEN(VROW_LEN),
    .PRE_LEN(PRE_LEN), .REF_LEN(REF_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_long(cpu_long), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .vid_req(vid_req), .vid_addr(vid_addr),
    .ref_pend(ref_pend), .cand_seq(cand_seq),
    .cand_addr(cand_addr), .word_done(word_done), .done_addr(done_addr),
    .row_drop(row_drop), .ref_start(ref_start),
    .cpu_ack(cpu_ack), .vid_valid(vid_valid), .vid_done(vid_done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .mux_col(mux_col),
    .mem_addr(mem_addr)
  );

  assign cpu_wait = cpu_req & ~cpu_ack;

  // R10: the CPU is told to wait while its word is outstanding
  a_r10_wait_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_ack) |-> cpu_wait);

endmodule

// File: tb/dram_share_ctrl_bench.sv
module dram_share_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int CW  = 4;
  localparam int PRE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          cpu_req = 1'b0, cpu_long = 1'b0, cpu_we = 1'b0, vid_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [AW-2:0] vid_addr = '0;

  logic          ack_m, wait_m, vv_m, vd_m, ras_m, cas_m, we_m, mux_m;
  logic [AW-1:0] ma_m;
  logic          ack_r, wait_r, vv_r, vd_r, ras_r, cas_r, we_r, mux_r;
  logic [AW-1:0] ma_r;

  dram_share_ctrl #(.ADDR_W(AW), .COL_W(CW), .REF_INTERVAL(100000)) u_dram_share_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_long(cpu_long), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_ack(ack_m), .cpu_wait(wait_m), .vid_req(vid_req),
    .vid_addr(vid_addr), .vid_valid(vv_m), .vid_done(vd_m), .ras_n(ras_m),
    .cas_n(cas_m), .we_n(we_m), .mux_col(mux_m), .mem_addr(ma_m));

  dram_share_ctrl #(.ADDR_W(AW), .COL_W(CW)) u_dram_share_ctrl_ref (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_long(cpu_long), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_ack(ack_r), .cpu_wait(wait_r), .vid_req(vid_req),
    .vid_addr(vid_addr), .vid_valid(vv_r), .vid_done(vd_r), .ras_n(ras_r),
    .cas_n(cas_r), .we_n(we_r), .mux_col(mux_r), .mem_addr(ma_r));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;
  int wait_err = 0, we_low = 0;
  logic [AW-1:0] adr1, adr2;

  // bench model of the open row
  bit            m_ok = 1'b0;
  logic [AW-1:0] m_last = '0;

  function automatic bit seq_ok(logic [AW-1:0] a);
    logic [AW-1:0] nx = m_last + 1'b1;
    return m_ok && (a == nx) && ((a >> CW) == (m_last >> CW));
  endfunction

  function automatic int word_cost(bit seq);
    return seq ? 4 : 4 + PRE;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cpu_op(input logic [AW-1:0] a, input bit lng, input bit we, input bit sel,
                        output int t1, output int t2);
    int t0, guard;
    bit fin, ackv;
    @(negedge clk);
    cpu_addr = a; cpu_long = lng; cpu_we = we; cpu_req = 1'b1;
    t0 = cyc; t1 = -1; t2 = -1; fin = 1'b0; guard = 0;
    while (!fin && guard < 100) begin
      @(negedge clk);
      guard++;
      ackv = sel ? ack_r : ack_m;
      if (!sel) begin
        if (!ack_m && !wait_m) wait_err++;
        if (!we_m) we_low++;
      end
      if (ackv) begin
        if (t1 < 0) begin t1 = cyc - t0; adr1 = sel ? ma_r : ma_m; end
        else        begin t2 = cyc - t0; adr2 = sel ? ma_r : ma_m; end
        if (!lng || t2 >= 0) fin = 1'b1;
      end
    end
    cpu_req = 1'b0;
  endtask

  // runs one access on the main instance and scores it against the model
  task automatic cpu_scored(input logic [AW-1:0] a, input bit lng, input bit we, input string req);
    int t1, t2, e1, e2;
    logic [AW-1:0] b = a + 1'b1;
    e1 = word_cost(seq_ok(a));
    m_ok = 1'b1; m_last = a;
    e2 = -1;
    if (lng) begin
      e2 = e1 + word_cost(seq_ok(b));
      m_last = b;
    end
    cpu_op(a, lng, we, 1'b0, t1, t2);
    check(req, "first word latency", t1, e1);
    check(req, "first word address", int'(adr1), int'(a));
    if (lng) begin
      check(req, "second word latency", t2, e2);
      check(req, "second word address", int'(adr2), int'(b));
    end
  endtask

  task automatic vid_op(input logic [AW-2:0] base, input int cpu_at, input logic [AW-1:0] ca,
                        output int t_first, output int nval, output int t_done,
                        output int t_ack, output int gaps, output int aerr);
    int t0, d, guard;
    bit lastv;
    logic [AW-1:0] expa;
    @(negedge clk);
    vid_addr = base; vid_req = 1'b1; t0 = cyc;
    t_first = -1; nval = 0; t_done = -1; t_ack = -1; gaps = 0; aerr = 0;
    lastv = 1'b0; guard = 0;
    if (cpu_at == 0) begin
      cpu_addr = ca; cpu_long = 1'b0; cpu_we = 1'b0; cpu_req = 1'b1;
    end
    while (guard < 100 && !(t_done >= 0 && (cpu_at < 0 || t_ack >= 0))) begin
      @(negedge clk);
      guard++;
      d = cyc - t0;
      if (vv_m) begin
        if (t_first < 0) t_first = d;
        else if (!lastv) gaps++;
        expa = {base, 1'b0} + AW'(2 * nval);
        if (ma_m != expa) aerr++;
        nval++;
      end
      lastv = vv_m;
      if (vd_m && t_done < 0) begin t_done = d; vid_req = 1'b0; end
      if (ack_m && t_ack < 0) begin t_ack = d; cpu_req = 1'b0; end
      if (cpu_at > 0 && d == cpu_at) begin
        cpu_addr = ca; cpu_long = 1'b0; cpu_we = 1'b0; cpu_req = 1'b1;
      end
    end
    m_ok = 1'b0;
    if (cpu_at >= 0) begin m_ok = 1'b1; m_last = ca; end
  endtask

  task automatic burst_scored(input logic [AW-2:0] base, input int cpu_at, input logic [AW-1:0] ca,
                              input string req);
    int tf, nv, td, ta, gp, ae;
    vid_op(base, cpu_at, ca, tf, nv, td, ta, gp, ae);
    check("R4", "first beat cycle", tf, 3);
    check("R4", "beat count", nv, 17);
    check("R4", "beat address errors", ae, 0);
    check("R4", "done pulse cycle", td, 20);
    check("R6", "beat gaps", gp, 0);
    if (cpu_at >= 0)
      check(req, "cpu ack after burst", ta, (cpu_at + 6 > 25) ? cpu_at + 6 : 25);
  endtask

  task automatic wait_ref_rise(output int s, output int width);
    bit prev, sig;
    int guard;
    prev = 1'b1; s = -1; width = 0; guard = 0;
    while (s < 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
      sig = !cas_r && !mux_r;
      if (sig && !prev) s = cyc;
      prev = sig;
    end
    width = 1;
    @(negedge clk);
    while (!cas_r && !mux_r && width < 100) begin
      width++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int t1, t2, s0, s1, w0, w1, base;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset / idle strobe state
    check("R11", "idle ras_n", int'(ras_m), 1);
    check("R11", "idle cas_n", int'(cas_m), 1);
    check("R11", "idle we_n", int'(we_m), 1);
    check("R11", "idle ack", int'(ack_m), 0);
    check("R11", "idle valid", int'(vv_m), 0);

    cpu_scored(12'h010, 1'b0, 1'b0, "R2");            // first word: precharge
    cpu_scored(12'h011, 1'b0, 1'b0, "R1");            // sequential
    cpu_scored(12'h011, 1'b0, 1'b0, "R2");            // repeated address
    cpu_scored(12'h012, 1'b1, 1'b0, "R3");            // long in the open row
    cpu_scored(12'h02E, 1'b1, 1'b0, "R2");            // jump, long
    cpu_scored(12'h030, 1'b0, 1'b0, "R1");            // sequential into new row? model decides
    cpu_scored(12'h03F, 1'b1, 1'b0, "R3");            // long crossing a row

    // R11 write enable only in write column cycles
    we_low = 0;
    cpu_scored(12'h041, 1'b0, 1'b0, "R11");
    check("R11", "we_n low cycles on read", we_low, 0);
    cpu_scored(12'h042, 1'b0, 1'b1, "R11");
    check("R11", "we_n low cycles on write", we_low, 3);

    burst_scored(11'h100, -1, '0, "R4");
    cpu_scored(12'h043, 1'b0, 1'b0, "R9");            // sequential but row forgotten
    burst_scored(11'h120, 2, 12'h050, "R6");          // CPU during burst
    burst_scored(11'h140, 0, 12'h051, "R5");          // simultaneous request

    // constrained random mix
    for (int i = 0; i < 150; i++) begin
      int r = int'($urandom % 10);
      if (r == 0) begin
        int at = int'($urandom % 24) - 1;
        burst_scored(AW'($urandom) >> 1, at, AW'($urandom), "R5");
      end else begin
        logic [AW-1:0] a = ($urandom % 2 == 0) ? m_last + 1'b1 : AW'($urandom);
        cpu_scored(a, ($urandom % 3) == 0, $urandom % 2 == 1, "R1");
      end
    end
    check("R10", "cycles with ack low and wait low", wait_err, 0);

    // refresh instance: period and length
    wait_ref_rise(s0, w0);
    wait_ref_rise(s1, w1);
    check("R7", "refresh period", s1 - s0, 250);
    check("R7", "refresh length", w1, 4);

    // R8: CPU word arriving with a due refresh waits behind it
    while (cyc != s1 + 248) @(negedge clk);
    cpu_op(12'h070, 1'b0, 1'b0, 1'b1, t1, t2);
    check("R8", "cpu word behind refresh", t1, 4 + 4 + PRE);

    // R9: refresh forgets the open row
    cpu_op(12'h071, 1'b0, 1'b0, 1'b1, t1, t2);
    check("R1", "sequential word on refresh instance", t1, 4);
    wait_ref_rise(s0, w0);
    cpu_op(12'h072, 1'b0, 1'b0, 1'b1, t1, t2);
    check("R9", "sequential word after refresh", t1, 4 + PRE);
    base = s0;

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule